// File: doc/BRIEF.md
# Sleep-Time Interrupt Capture and Replay

This block sits between a set of external interrupt lines and a parent interrupt controller that may lose power. Each line is synchronized and checked for a qualifying event, which is either an edge or a level of a programmed polarity. When an unmasked line has an event, its status bit is set. Capture runs whether or not the block is enabled. While the parent is asleep, the status bits therefore hold every event that would otherwise be lost.

Before wake-up, software acknowledges the stale bits. On resume it sets the flush bit. The block then emits one single-cycle pulse on each parent output whose status bit is set, clears those bits, and drops the flush bit again.

Software uses a simple 32-bit register bus with word addressing. Mask, sense and polarity are each held per line. Each of the three has its own write-one-to-set register and its own write-one-to-clear register. A write-one-to-acknowledge register clears status bits. One control word carries the enable, edge-only and flush bits.

Top module: `wake_irq_capture`

## Requirements
- R1: Every per-line group packs 32 lines per word. Line n is held in the word at group base + (n/32)*4, at bit n%32. The byte offsets of the groups are:

  | Group | Offset |
  |---|---|
  | status | 0x000 |
  | acknowledge | 0x040 |
  | mask-set | 0x0C0 |
  | mask-clear | 0x100 |
  | sense-set | 0x180 |
  | sense-clear | 0x1C0 |
  | polarity-set | 0x240 |
  | polarity-clear | 0x280 |
  | control | 0x300 |

  The control word has no per-line words. Its fields are enable at bit 0, edge-only at bit 1 and flush at bit 2.
- R2: Writing 1 to a bit of a set register sets that line's mask, sense or polarity bit. Writing 1 to a bit of a clear register clears it. Written zeros change nothing.
- R3: Sense 1 selects level triggering and sense 0 selects edge triggering. Polarity 1 selects rising edge or high level, and polarity 0 selects falling edge or low level. A level line records on every cycle its synchronized input matches the polarity. An edge line records once per matching transition.
- R4: A line whose mask bit is 1 never sets its status bit.
- R5: Status capture works the same with the enable bit at 0 as at 1.
- R6: While edge-only is 1, lines whose sense bit is 1 (level) are not recorded.
- R7: Writing 1 to an acknowledge bit clears that status bit. If an event for the same line arrives in the same cycle, the bit stays set.
- R8: On the cycle after the flush bit is written as 1, each parent output whose status bit was set pulses high for exactly one cycle. Those status bits clear, and the flush bit reads back 0. Parent outputs are low at all other times.
- R9: Read data appears on the cycle after a read request and is 0 on all other cycles. Writes to the status group are ignored. Reads of the acknowledge, set and clear groups, and of any word beyond the implemented lines, return 0. The control word reads back as {flush, edge-only, enable} in bits 2:0.
- R10: After reset, every mask bit is 1, every sense bit is 0, every polarity bit is 1, and status, control and parent outputs are 0.
- R11: An input change sampled at clock edge k appears in the status bit at edge k+2, because it passes through a two-flop synchronizer first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Bus access strobe, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 10 | Word address, byte address bits 11:2 |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read request |
| irq_i | input | NUM_LINES | External interrupt lines, asynchronous |
| parent_o | output | NUM_LINES | Replay pulses to the parent controller |

## Verification
The assertions assume that at most one bus access happens per cycle and that its fields are stable across the sampling edge. They also assume that any control write that starts a flush is a deliberate single write, so the self-clear check can allow for a write of 1 arriving in the same cycle.

The bench keeps within these assumptions. It drives every bus access and every interrupt-line change only at falling clock edges, one access per cycle. It also randomizes line toggles and register accesses only among legal, word-aligned addresses, so level lines, edge lines, acknowledges and flushes interleave with no protocol violation.

// File: rtl/wic_pkg.sv
package wic_pkg;
  typedef enum logic [5:0] {
    GRP_STAT = 6'd0,
    GRP_ACK  = 6'd1,
    GRP_MSET = 6'd3,
    GRP_MCLR = 6'd4,
    GRP_SSET = 6'd6,
    GRP_SCLR = 6'd7,
    GRP_PSET = 6'd9,
    GRP_PCLR = 6'd10,
    GRP_CTRL = 6'd12
  } grp_e;

  localparam int CTL_EN    = 0;
  localparam int CTL_EDGE  = 1;
  localparam int CTL_FLUSH = 2;
  localparam int WORD_BITS = 32;
endpackage

// File: rtl/wic_sync.sv
module wic_sync #(
  parameter int NUM_LINES = 64
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] irq_i,
  input  logic [NUM_LINES-1:0] sense_i,
  input  logic [NUM_LINES-1:0] pol_i,
  output logic [NUM_LINES-1:0] evt_o
);
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    logic meta_q, sync_q, prev_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        meta_q <= irq_i[i];
        sync_q <= meta_q;
        prev_q <= sync_q;
      end
    end
    // level: match polarity; edge: transition toward polarity
    always_comb begin
      if (sense_i[i])   evt_o[i] = (sync_q == pol_i[i]);
      else if (pol_i[i]) evt_o[i] = sync_q & ~prev_q;
      else              evt_o[i] = ~sync_q & prev_q;
    end
  end
endmodule

// File: rtl/wic_regs.sv
module wic_regs
  import wic_pkg::*;
#(
  parameter int NUM_LINES = 64
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [9:0]           addr_i,
  input  logic [31:0]          wdata_i,
  input  logic [NUM_LINES-1:0] status_i,
  output logic [NUM_LINES-1:0] mask_o,
  output logic [NUM_LINES-1:0] sense_o,
  output logic [NUM_LINES-1:0] pol_o,
  output logic [NUM_LINES-1:0] ack_o,
  output logic                 edge_only_o,
  output logic                 flush_o,
  output logic [31:0]          rdata_o
);
  localparam int NUM_WORDS = (NUM_LINES + WORD_BITS - 1) / WORD_BITS;

  logic [5:0] grp;
  logic [3:0] word;
  logic       wr, rd;
  assign grp  = addr_i[9:4];
  assign word = addr_i[3:0];
  assign wr   = req_i & we_i;
  assign rd   = req_i & ~we_i;

  logic [NUM_LINES-1:0] hit;
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_hit
    localparam logic [3:0] WI = 4'(i / WORD_BITS);
    assign hit[i] = wr && (word == WI) && wdata_i[i % WORD_BITS];
  end

  logic [NUM_LINES-1:0] mset, mclr, sset, sclr, pset, pclr;
  assign mset  = hit & {NUM_LINES{grp == GRP_MSET}};
  assign mclr  = hit & {NUM_LINES{grp == GRP_MCLR}};
  assign sset  = hit & {NUM_LINES{grp == GRP_SSET}};
  assign sclr  = hit & {NUM_LINES{grp == GRP_SCLR}};
  assign pset  = hit & {NUM_LINES{grp == GRP_PSET}};
  assign pclr  = hit & {NUM_LINES{grp == GRP_PCLR}};
  assign ack_o = hit & {NUM_LINES{grp == GRP_ACK}};

  logic [NUM_LINES-1:0] mask_q, sense_q, pol_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q  <= '1;
      sense_q <= '0;
      pol_q   <= '1;
    end else begin
      mask_q  <= (mask_q  | mset) & ~mclr;
      sense_q <= (sense_q | sset) & ~sclr;
      pol_q   <= (pol_q   | pset) & ~pclr;
    end
  end
  assign mask_o  = mask_q;
  assign sense_o = sense_q;
  assign pol_o   = pol_q;

  logic ctrl_wr, en_q, edge_q, flush_q;
  assign ctrl_wr = wr && (grp == GRP_CTRL) && (word == 4'd0);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      edge_q  <= 1'b0;
      flush_q <= 1'b0;
    end else if (ctrl_wr) begin
      en_q    <= wdata_i[CTL_EN];
      edge_q  <= wdata_i[CTL_EDGE];
      flush_q <= wdata_i[CTL_FLUSH];
    end else begin
      flush_q <= 1'b0; // self-clear after one cycle
    end
  end
  assign edge_only_o = edge_q;
  assign flush_o     = flush_q;

  logic [31:0] stat_words [NUM_WORDS];
  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_sw
    for (genvar b = 0; b < WORD_BITS; b++) begin : g_sb
      if (w * WORD_BITS + b < NUM_LINES) begin : g_live
        assign stat_words[w][b] = status_i[w*WORD_BITS+b];
      end else begin : g_pad
        assign stat_words[w][b] = 1'b0;
      end
    end
  end

  logic [31:0] rdata_d, rdata_q;
  always_comb begin
    rdata_d = '0;
    if (rd) begin
      if (grp == GRP_STAT) begin
        for (int w = 0; w < NUM_WORDS; w++) begin
          if (word == w[3:0]) rdata_d = stat_words[w];
        end
      end else if (grp == GRP_CTRL && word == 4'd0) begin
        rdata_d[CTL_EN]    = en_q;
        rdata_d[CTL_EDGE]  = edge_q;
        rdata_d[CTL_FLUSH] = flush_q;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= rdata_d;
  end
  assign rdata_o = rdata_q;
endmodule

// File: rtl/wic_capture.sv
module wic_capture #(
  parameter int NUM_LINES = 64
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] evt_i,
  input  logic [NUM_LINES-1:0] mask_i,
  input  logic [NUM_LINES-1:0] sense_i,
  input  logic                 edge_only_i,
  input  logic [NUM_LINES-1:0] ack_i,
  input  logic                 flush_i,
  output logic [NUM_LINES-1:0] status_o,
  output logic [NUM_LINES-1:0] parent_o
);
  logic [NUM_LINES-1:0] rec, keep, status_q, parent_q;

  assign rec  = evt_i & ~mask_i & ~({NUM_LINES{edge_only_i}} & sense_i);
  assign keep = ~ack_i & ~{NUM_LINES{flush_i}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      parent_q <= '0;
    end else begin
      status_q <= (status_q & keep) | rec; // new event wins over clear
      parent_q <= flush_i ? status_q : '0;
    end
  end
  assign status_o = status_q;
  assign parent_o = parent_q;
endmodule

// File: rtl/wake_irq_capture.sv
module wake_irq_capture #(
  parameter int NUM_LINES = 64
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [9:0]           addr_i,
  input  logic [31:0]          wdata_i,
  output logic [31:0]          rdata_o,
  input  logic [NUM_LINES-1:0] irq_i,
  output logic [NUM_LINES-1:0] parent_o
);
  logic [NUM_LINES-1:0] evt_w, mask_w, sense_w, pol_w, ack_w, status_w;
  logic                 edge_only_w, flush_w;

  wic_sync #(.NUM_LINES(NUM_LINES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .irq_i   (irq_i),
    .sense_i (sense_w),
    .pol_i   (pol_w),
    .evt_o   (evt_w)
  );

  wic_regs #(.NUM_LINES(NUM_LINES)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .we_i        (we_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .status_i    (status_w),
    .mask_o      (mask_w),
    .sense_o     (sense_w),
    .pol_o       (pol_w),
    .ack_o       (ack_w),
    .edge_only_o (edge_only_w),
    .flush_o     (flush_w),
    .rdata_o     (rdata_o)
  );

  wic_capture #(.NUM_LINES(NUM_LINES)) u_cap (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .evt_i       (evt_w),
    .mask_i      (mask_w),
    .sense_i     (sense_w),
    .edge_only_i (edge_only_w),
    .ack_i       (ack_w),
    .flush_i     (flush_w),
    .status_o    (status_w),
    .parent_o    (parent_o)
  );
endmodule

// File: rtl/wic_checker.sv
module wic_checker #(
  parameter int NUM_LINES = 64
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 req_i,
  input logic                 we_i,
  input logic [9:0]           addr_i,
  input logic [31:0]          wdata_i,
  input logic [31:0]          rdata_o,
  input logic [NUM_LINES-1:0] parent_o,
  input logic [NUM_LINES-1:0] status_i,
  input logic [NUM_LINES-1:0] mask_i,
  input logic                 flush_i
);
  logic ctrl_flush_wr;
  assign ctrl_flush_wr = req_i && we_i && addr_i == 10'h0C0 && wdata_i[2];

  p_flush_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> parent_o == $past(status_i));

  p_quiet_parent_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flush_i |=> parent_o == '0);

  p_flush_selfclr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_i && !ctrl_flush_wr) |=> !flush_i);

  p_masked_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (status_i & ~$past(status_i) & $past(mask_i)) == '0);

  p_wo_read_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && (addr_i[9:4] inside {6'd1, 6'd3, 6'd4, 6'd6, 6'd7, 6'd9, 6'd10}))
      |=> rdata_o == '0);

  p_idle_rdata_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> rdata_o == '0);
endmodule

bind wake_irq_capture wic_checker #(.NUM_LINES(NUM_LINES)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .rdata_o  (rdata_o),
  .parent_o (parent_o),
  .status_i (status_w),
  .mask_i   (mask_w),
  .flush_i  (flush_w)
);

// File: tb/sim_wake_irq_capture.sv
module sim_wake_irq_capture;
  localparam int CLK_PERIOD = 10;
  localparam int N = 64;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_i = 1'b0, we_i = 1'b0;
  logic [9:0]    addr_i = '0;
  logic [31:0]   wdata_i = '0;
  logic [31:0]   rdata_o;
  logic [N-1:0]  irq_i = '0;
  logic [N-1:0]  parent_o;

  int total = 0, bad = 0;
  bit done = 0;

  wake_irq_capture #(.NUM_LINES(N)) u0 (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  // reference model
  logic [N-1:0] m_h0, m_h1, m_h2, m_mask, m_sense, m_pol, m_status, m_parent;
  logic [N-1:0] m_evt, m_rec, m_bits;
  logic         m_en, m_edge, m_flush;
  logic [31:0]  m_rdata;
  int           g, wd;

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      {m_h0, m_h1, m_h2} = '0;
      m_mask = '1; m_sense = '0; m_pol = '1;
      m_status = '0; m_parent = '0;
      {m_en, m_edge, m_flush} = '0;
      m_rdata = '0;
    end else begin
      for (int i = 0; i < N; i++)
        m_evt[i] = m_sense[i] ? (m_h1[i] == m_pol[i])
                 : (m_pol[i] ? (m_h1[i] & !m_h2[i]) : (!m_h1[i] & m_h2[i]));
      m_rec = m_evt & ~m_mask & ~(m_edge ? m_sense : '0);
      g  = int'(addr_i[9:4]);
      wd = int'(addr_i[3:0]);
      m_bits = '0;
      if (req_i && we_i)
        for (int i = 0; i < 32; i++)
          if (wd*32 + i < N && wdata_i[i]) m_bits[wd*32+i] = 1'b1;
      m_rdata = '0;
      if (req_i && !we_i) begin
        if (g == 0 && wd < N/32) m_rdata = m_status[wd*32 +: 32];
        else if (g == 12 && wd == 0) m_rdata = {29'd0, m_flush, m_edge, m_en};
      end
      m_parent = m_flush ? m_status : '0;
      m_status = (m_status & ~((g == 1) ? m_bits : '0) & ~(m_flush ? {N{1'b1}} : '0)) | m_rec;
      if (g == 3)  m_mask  = m_mask  | m_bits;
      if (g == 4)  m_mask  = m_mask  & ~m_bits;
      if (g == 6)  m_sense = m_sense | m_bits;
      if (g == 7)  m_sense = m_sense & ~m_bits;
      if (g == 9)  m_pol   = m_pol   | m_bits;
      if (g == 10) m_pol   = m_pol   & ~m_bits;
      if (req_i && we_i && g == 12 && wd == 0) {m_flush, m_edge, m_en} = wdata_i[2:0];
      else m_flush = 1'b0;
      m_h2 = m_h1; m_h1 = m_h0; m_h0 = irq_i;
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      total++;
      if (parent_o !== m_parent) begin
        bad++;
        $display("FAIL R8 parent_o act=%h exp=%h", parent_o, m_parent);
      end
      total++;
      if (rdata_o !== m_rdata) begin
        bad++;
        $display("FAIL R9 rdata_o act=%h exp=%h", rdata_o, m_rdata);
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // called at a falling edge, returns at the next falling edge
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    req_i = 1; we_i = 1; addr_i = a[11:2]; wdata_i = d;
    @(negedge clk_i);
    req_i = 0; we_i = 0; wdata_i = '0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    req_i = 1; we_i = 0; addr_i = a[11:2];
    @(negedge clk_i);
    req_i = 0;
    chk(tag, {32'd0, rdata_o}, {32'd0, exp});
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R10 parent after reset", {32'd0, parent_o}, 64'd0);
    rst_ni = 1;
    @(negedge clk_i);
    rd(12'h300, 32'h0, "R10 control reset");
    rd(12'h000, 32'h0, "R10 status reset");
    // R10: default mask hides a toggle
    irq_i[5] = 1; repeat (5) @(negedge clk_i); irq_i[5] = 0;
    rd(12'h000, 32'h0, "R10 R4 masked by default");

    // R2 R1: unmask lines 3 and 40 (word1 bit8), enable stays 0
    wr(12'h100, 32'h0000_0008);
    wr(12'h104, 32'h0000_0100);
    irq_i[3] = 1;
    repeat (2) @(posedge clk_i);
    @(negedge clk_i);
    rd(12'h000, 32'h0, "R11 not yet visible");
    rd(12'h000, 32'h8, "R11 R3 R5 rising edge recorded with enable 0");
    irq_i[3] = 0; repeat (4) @(negedge clk_i);
    rd(12'h000, 32'h8, "R3 falling edge ignored on rising line");

    // R7: acknowledge
    wr(12'h040, 32'h0000_0008);
    rd(12'h000, 32'h0, "R7 ack clears");

    // falling edge on line 40
    wr(12'h0C4, 32'h0000_0100);       // mask again
    irq_i[40] = 1; repeat (4) @(negedge clk_i);
    wr(12'h284, 32'h0000_0100);       // polarity low
    wr(12'h104, 32'h0000_0100);       // unmask
    irq_i[40] = 0; repeat (4) @(negedge clk_i);
    rd(12'h004, 32'h0000_0100, "R1 R3 falling edge line 40");

    // R4: masked line 7 never records
    irq_i[7] = 1; repeat (4) @(negedge clk_i); irq_i[7] = 0; repeat (4) @(negedge clk_i);
    rd(12'h000, 32'h0, "R4 masked line 7");

    // level high on line 12
    irq_i[12] = 1;
    wr(12'h180, 32'h0000_1000);
    wr(12'h100, 32'h0000_1000);
    repeat (4) @(negedge clk_i);
    rd(12'h000, 32'h0000_1000, "R3 level high recorded");
    wr(12'h040, 32'h0000_1000);
    rd(12'h000, 32'h0000_1000, "R7 ack loses to simultaneous event");

    // R6: edge-only blocks level line
    wr(12'h300, 32'h0000_0002);
    wr(12'h040, 32'h0000_1000);
    repeat (3) @(negedge clk_i);
    rd(12'h000, 32'h0, "R6 level line not recorded in edge-only");
    rd(12'h300, 32'h2, "R9 control readback");

    // level low on line 20 with edge-only off
    wr(12'h300, 32'h0000_0000);
    wr(12'h180, 32'h0010_0000);
    wr(12'h280, 32'h0010_0000);
    wr(12'h100, 32'h0010_0000);
    irq_i[12] = 0;
    repeat (3) @(negedge clk_i);
    rd(12'h000, 32'h0010_1000, "R3 level low line 20");
    wr(12'h0C0, 32'h0010_1000);       // mask 12 and 20
    wr(12'h040, 32'h0010_1000);
    rd(12'h000, 32'h0, "R2 R7 mask then ack");

    // R9: status writes ignored, write-only reads zero, padding word zero
    wr(12'h000, 32'hFFFF_FFFF);
    rd(12'h004, 32'h0000_0100, "R9 status write ignored");
    rd(12'h0C0, 32'h0, "R9 mask-set reads zero");
    rd(12'h008, 32'h0, "R9 word beyond lines");

    // R8: flush pulse
    wr(12'h300, 32'h0000_0007);
    chk("R8 no pulse yet", parent_o, 64'd0);
    @(negedge clk_i);
    chk("R8 pulse line 40", parent_o, 64'd1 << 40);
    @(negedge clk_i);
    chk("R8 pulse one cycle", parent_o, 64'd0);
    rd(12'h300, 32'h3, "R8 flush self-clears");
    rd(12'h004, 32'h0, "R8 status cleared");

    // mixed traffic against the model
    for (int k = 0; k < 3000; k++) begin
      if ($urandom_range(0, 3) == 0) irq_i = irq_i ^ (64'd1 << $urandom_range(0, N-1));
      case ($urandom_range(0, 9))
        0: wr(12'h040 + 12'(4 * $urandom_range(0, 1)), $urandom);
        1: wr(12'h0C0 + 12'(4 * $urandom_range(0, 1)), $urandom & $urandom);
        2: wr(12'h100 + 12'(4 * $urandom_range(0, 1)), $urandom);
        3: wr(12'h180 + 12'(4 * $urandom_range(0, 1)), $urandom);
        4: wr(12'h1C0 + 12'(4 * $urandom_range(0, 1)), $urandom);
        5: wr(12'h240 + 12'(4 * $urandom_range(0, 1)), $urandom);
        6: wr(12'h280 + 12'(4 * $urandom_range(0, 1)), $urandom);
        7: wr(12'h300, 32'($urandom_range(0, 7)));
        8: begin
             req_i = 1; we_i = 0; addr_i = 10'($urandom_range(0, 1));
             @(negedge clk_i); req_i = 0;
           end
        default: @(negedge clk_i);
      endcase
    end
    repeat (4) @(negedge clk_i);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule